// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks which page frame to give up when memory is full. It uses the second-chance clock policy. Each frame has one reference flag, and any use of the frame sets it. A hand pointer walks the frames as a ring. When an eviction is asked for, the hand looks at one frame per clock cycle:
- If the frame's flag is set, the scan clears the flag and moves on. This is the frame's second chance.
- If the flag is clear, that frame is the victim. The block reports it and parks the hand just past it.

If every flag was set, the hand clears them all in one full lap. It then comes back to where it started and takes that frame, so the policy acts like FIFO under heavy pressure.

The eviction request is a valid/ready handshake: `req_valid` is accepted on a clock edge where `req_ready` is high. `req_ready` is low for the whole scan. A request raised while the scan runs is not stored, and the requester must hold it until it sees ready. The victim report is a one-cycle pulse with no back-pressure. The access strobe is a plain control input that is taken on every cycle it is high, at any time.

Top module: `clock_evict_sel`

## Requirements
- R1: After reset no frame is flagged, the hand is at frame 0, `busy` and `victim_valid` are low and `req_ready` is high. The first eviction therefore picks frame 0 after one examination.
- R2: A cycle with `acc_valid` high sets the flag of frame `acc_idx`. This holds whether or not a scan is running.
- R3: An eviction request is accepted only when `req_valid` and `req_ready` are both high on an edge, and `req_ready` is the inverse of `busy`. A request made while `busy` is high is ignored: it neither restarts nor lengthens the scan.
- R4: While `busy` is high, the frame under the hand is examined once per cycle. If its flag is set, the flag is cleared and the hand advances by one, wrapping from the last frame to frame 0.
- R5: The first examined frame whose flag is clear becomes the victim. On the next cycle `victim_valid` is high for exactly one cycle with `victim_idx` equal to that frame, and `busy` is already low in that cycle.
- R6: Once a victim is reported, the hand points to the frame after it, modulo the frame count, and the victim's flag is clear.
- R7: If every flag is set when the scan starts and no access arrives during it, the scan clears all flags in one lap and picks the frame where it started. `busy` stays high for exactly N+1 cycles.
- R8: An access to the frame under the hand in the cycle that frame is examined takes priority. The frame counts as referenced, its flag is left set, and the hand moves on without choosing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Frame access strobe |
| acc_idx | input | $clog2(NUM_FRAMES) | Index of the accessed frame |
| req_valid | input | 1 | Eviction request valid |
| req_ready | output | 1 | Eviction request ready (high when idle) |
| busy | output | 1 | Scan in progress |
| victim_valid | output | 1 | One-cycle pulse: victim chosen |
| victim_idx | output | $clog2(NUM_FRAMES) | Index of the chosen victim |

## Verification
A stale or misplaced hand shows at the ports on the very next eviction: the reported victim index is wrong, and the scan length differs from what the flag pattern predicts. A flag that fails to set or clear also surfaces only through scans. It gives a victim that should have been skipped, or a lap that runs one cycle too long or too short. For that reason the flags are exercised with patterns that make each scan's length and result distinct. A bench model that tracks hand and flags on every clock exposes any such divergence within the scan in which the wrong state is first read.

// File: rtl/clock_evict_pkg.sv
package clock_evict_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/clock_ref_flags.sv
module clock_ref_flags #(
  parameter int NUM_FRAMES = 8,
  parameter int IW = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [IW-1:0]         acc_idx,
  input  logic                  clr_en,
  input  logic [IW-1:0]         clr_idx,
  output logic [NUM_FRAMES-1:0] flags
);
  // One flag per frame; a set from an access wins over a clear from the scan.
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_flag
    logic set_hit;
    logic clr_hit;
    assign set_hit = acc_valid && (acc_idx == IW'(g));
    assign clr_hit = clr_en && (clr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags[g] <= 1'b0;
      else if (set_hit) flags[g] <= 1'b1;
      else if (clr_hit) flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/clock_hand.sv
module clock_hand #(
  parameter int NUM_FRAMES = 8,
  parameter int IW = $clog2(NUM_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] hand
);
  localparam logic [IW-1:0] LAST = IW'(NUM_FRAMES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hand <= '0;
    else if (adv) hand <= (hand == LAST) ? '0 : hand + 1'b1;
  end
endmodule

// File: rtl/clock_scan_fsm.sv
module clock_scan_fsm
  import clock_evict_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int IW = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  acc_valid,
  input  logic [IW-1:0]         acc_idx,
  input  logic [IW-1:0]         hand,
  input  logic [NUM_FRAMES-1:0] flags,
  output logic                  req_ready,
  output logic                  busy,
  output logic                  adv,
  output logic                  clr_en,
  output logic                  done,
  output logic [IW-1:0]         victim
);
  scan_state_e state_q;
  logic        cur_ref;

  // Frame under the hand counts as referenced if flagged or accessed right now.
  always_comb begin
    cur_ref   = flags[hand] | (acc_valid && (acc_idx == hand));
    busy      = (state_q == SCAN_RUN);
    req_ready = !busy;
    adv       = busy;
    clr_en    = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      done    <= 1'b0;
      victim  <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SCAN_IDLE: if (req_valid) state_q <= SCAN_RUN;
        SCAN_RUN: begin
          if (!cur_ref) begin
            state_q <= SCAN_IDLE;
            done    <= 1'b1;
            victim  <= hand;
          end
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clock_evict_sel.sv
module clock_evict_sel #(
  parameter int NUM_FRAMES = 8,
  parameter int IW = $clog2(NUM_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_idx,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          busy,
  output logic          victim_valid,
  output logic [IW-1:0] victim_idx
);
  logic [IW-1:0]         hand;
  logic [NUM_FRAMES-1:0] flags;
  logic                  adv;
  logic                  clr_en;

  clock_ref_flags #(.NUM_FRAMES(NUM_FRAMES), .IW(IW)) u_flags (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .clr_en(clr_en), .clr_idx(hand), .flags(flags)
  );

  clock_hand #(.NUM_FRAMES(NUM_FRAMES), .IW(IW)) u_hand (
    .clk(clk), .rst_n(rst_n), .adv(adv), .hand(hand)
  );

  clock_scan_fsm #(.NUM_FRAMES(NUM_FRAMES), .IW(IW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_valid(acc_valid),
    .acc_idx(acc_idx), .hand(hand), .flags(flags), .req_ready(req_ready),
    .busy(busy), .adv(adv), .clr_en(clr_en), .done(victim_valid),
    .victim(victim_idx)
  );
endmodule

// File: rtl/clock_evict_sel_chk.sv
module clock_evict_sel_chk #(
  parameter int NUM_FRAMES = 8,
  parameter int IW = $clog2(NUM_FRAMES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_valid,
  input logic [IW-1:0]         acc_idx,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  busy,
  input logic                  victim_valid,
  input logic [IW-1:0]         victim_idx,
  input logic [IW-1:0]         hand,
  input logic [NUM_FRAMES-1:0] flags
);
  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] h);
    return (h == IW'(NUM_FRAMES - 1)) ? '0 : h + 1'b1;
  endfunction

  logic acc_in_range;
  assign acc_in_range = ({1'b0, acc_idx} < (IW+1)'(NUM_FRAMES));

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R3
  AST_ACCESS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_in_range) |=> flags[$past(acc_idx)]); // R2
  AST_HAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (hand == nxt($past(hand)))); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> !busy); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> !victim_valid); // R5
  AST_HAND_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> (hand == nxt(victim_idx))); // R6
  AST_VICTIM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> !flags[victim_idx]); // R6
endmodule

bind clock_evict_sel clock_evict_sel_chk #(.NUM_FRAMES(NUM_FRAMES), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
  .req_valid(req_valid), .req_ready(req_ready), .busy(busy),
  .victim_valid(victim_valid), .victim_idx(victim_idx), .hand(hand), .flags(flags)
);

// File: tb/clock_evict_sel_bench.sv
module clock_evict_sel_bench;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic req_valid = 1'b0;
  logic req_ready, busy, victim_valid;
  logic [IW-1:0] victim_idx;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  clock_evict_sel #(.NUM_FRAMES(N)) u_clock_evict_sel (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .req_valid(req_valid), .req_ready(req_ready), .busy(busy),
    .victim_valid(victim_valid), .victim_idx(victim_idx)
  );

  // Behavioural reference model.
  bit m_flag[N];
  int m_hand;
  bit m_busy;
  bit m_done;
  int m_vic;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      foreach (m_flag[i]) m_flag[i] = 1'b0;
      m_hand = 0; m_busy = 1'b0; m_done = 1'b0; m_vic = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        if (m_flag[m_hand] || (acc_valid && int'(acc_idx) == m_hand)) begin
          m_flag[m_hand] = 1'b0;
        end else begin
          m_done = 1'b1; m_vic = m_hand; m_busy = 1'b0;
        end
        m_hand = (m_hand + 1) % N;
      end else if (req_valid) begin
        m_busy = 1'b1;
      end
      if (acc_valid) m_flag[int'(acc_idx)] = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == m_busy, "R4 busy", busy, m_busy);
      check(req_ready == !m_busy, "R3 ready", req_ready, !m_busy);
      check(victim_valid == m_done, "R5 done", victim_valid, m_done);
      if (m_done) check(int'(victim_idx) == m_vic, "R6 victim", victim_idx, m_vic);
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic touch(input int idx);
    @(negedge clk);
    acc_valid = 1'b1; acc_idx = IW'(idx);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // Request an eviction, optionally keep req_valid high for extra scan cycles.
  task automatic evict(input int exp_vic, input int exp_len, input int hold, input string req);
    int len = 0;
    int guard = 0;
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    if (hold == 0) req_valid = 1'b0;
    while (!victim_valid && guard < 100) begin
      if (busy) len++;
      if (len > hold) req_valid = 1'b0;
      guard++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(victim_valid == 1'b1, req, victim_valid, 1);
    check(int'(victim_idx) == exp_vic, req, victim_idx, exp_vic);
    check(len == exp_len, req, len, exp_len);
    check(busy == 1'b0, req, busy, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(victim_valid == 1'b0, "R1 done", victim_valid, 0);
    evict(0, 1, 0, "R1 first victim");
    // R4: two flagged frames skipped and cleared
    touch(1); touch(2);
    evict(3, 3, 0, "R4 skip flagged");
    // R7: all flags set, full lap; R3: request held during scan is ignored
    for (int i = 0; i < N; i++) touch(i);
    evict(4, N + 1, 4, "R7 full lap");
    @(negedge clk);
    check(busy == 1'b0, "R3 no restart", busy, 0);
    // R8: access held on frame 5 while the hand examines it
    @(negedge clk);
    acc_valid = 1'b1; acc_idx = IW'(5);
    evict(6, 2, 0, "R8 access priority");
    acc_valid = 1'b0;
    // R2: frame 7 accessed, hand at 7 skips it; then R6 the hand parked after victim 0
    touch(7);
    evict(0, 2, 0, "R2 access sets flag");
    evict(1, 1, 0, "R6 hand after victim");
    // R8 follow-up: frame 5 kept its flag, so it is skipped
    evict(2, 1, 0, "R6 next");
    evict(3, 1, 0, "R6 next");
    evict(4, 1, 0, "R6 next");
    evict(6, 2, 0, "R8 flag survived");
    // Random traffic, compared against the model each cycle
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      acc_valid = ($urandom_range(0, 1) == 1);
      acc_idx   = IW'($urandom_range(0, N - 1));
      req_valid = ($urandom_range(0, 4) == 0);
    end
    @(negedge clk);
    acc_valid = 1'b0; req_valid = 1'b0;
    repeat (3 * N) @(negedge clk);
    finish_run();
  end
endmodule